// File: doc/BRIEF.md
# Line Test Pattern Generator

This block sits on the transmit bit stream of a single-channel T1/E1 line interface, ahead of line coding. A 3-bit test selector chooses what goes out on each bit slot. The options are user data, a steady stream of ones, two repeating loop codes, or a quasi-random test sequence. The quasi-random sequence can be inverted and can carry single-bit errors on request. A separate automatic override forces ones whenever the receive side reports loss of signal and the override is enabled.

The block produces one registered bit for each cycle in which the bit-clock enable is high, together with a valid flag. Line coding, pulse shaping and clock selection belong to neighbouring blocks.

Top module: `line_pattern_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `tx_valid` and `tx_bit` become 0. The quasi-random register is loaded with the seed, and the loop-code phase, zero-run count, error request and stored selector all return to 0.
- R2: `tx_valid` is `bit_en` delayed by one clock. `tx_bit` changes only in the clock after a cycle with `bit_en` high. No generator state moves on cycles with `bit_en` low.
- R3: With `test_sel` = 3'b000, `tx_bit` equals the `user_bit` sampled on the same `bit_en` cycle.
- R4: With `test_sel` = 3'b001, `tx_bit` is 1 and `user_bit` has no effect.
- R5: With `test_sel` = 3'b010, the output repeats the 5-bit loop-up word 0,0,0,0,1 in that order.
- R6: With `test_sel` = 3'b011, the output repeats the 3-bit loop-down word 0,0,1 in that order.
- R7: On the first enabled bit whose `test_sel` differs from the selector of the previous enabled bit, a loop code starts at its first bit.
- R8: With `test_sel[2]` = 1, the raw bit is r = s[19] XOR s[16] of a 20-bit register s. On each such bit, s becomes {s[18:0], r}. The default seed is 20'hFFFFF. The register holds while another mode is selected.
- R9: If the previous ZERO_RUN (default 14) bits of the quasi-random stream were all 0, the next bit is forced to 1. The check counts only bits taken while a quasi-random mode is selected, before inversion.
- R10: `test_sel[0]` = 1 in a quasi-random mode inverts the sequence bit.
- R11: With `test_sel[2:1]` = 2'b11, each rising edge of `err_strobe` flips exactly one later output bit. Edges that occur while `test_sel[2:1]` is not 2'b11 are discarded.
- R12: When `auto_ones_en` and `rx_los` are both high, `tx_bit` is 1 whatever `test_sel` holds. Loop phase, quasi-random state, stored selector and pending error all hold. With only one of the two high, there is no override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable; one output bit per high cycle |
| user_bit | input | 1 | User transmit data |
| test_sel | input | 3 | Test pattern selector |
| auto_ones_en | input | 1 | Enables all-ones on receive loss of signal |
| rx_los | input | 1 | Receive loss-of-signal flag |
| err_strobe | input | 1 | Asynchronous error-insert request; rising edge counts |
| tx_bit | output | 1 | Outgoing bit |
| tx_valid | output | 1 | High the cycle after an enabled bit slot |

## Verification
The bench instantiates the block with a short zero-run limit, so the forced-one rule fires often. A design that counted zeros after inversion, or that reset the count wrongly, would then drift from the arithmetic model within a few hundred bits. Loop codes are switched in the middle of a word. A design that kept the old phase would emit a shifted word. Error strobes are sent both in and out of the error modes. A design that discarded no stale edges, or that flipped more than one bit per edge, would show extra inverted bits. Idle gaps and loss-of-signal overrides are placed inside every sequence. A generator that advanced on disabled or overridden slots would shift the rest of the stream.

// File: rtl/lpg_pkg.sv
// Shared constants for the line test pattern generator.
// Assumes a single 20-stage quasi-random register with two feedback taps.
package lpg_pkg;
    localparam int QRS_W      = 20;
    localparam int QRS_TAP_HI = 19;
    localparam int QRS_TAP_LO = 16;

    localparam logic [2:0] SEL_DATA = 3'b000;
    localparam logic [2:0] SEL_ONES = 3'b001;
    localparam logic [2:0] SEL_LUP  = 3'b010;
    localparam logic [2:0] SEL_LDN  = 3'b011;
endpackage

// File: rtl/lpg_qrs.sv
// Quasi-random bit source: 20-stage shift register with feedback from two
// taps, and a forced one after ZERO_RUN consecutive zeros of its own output.
// Assumes advance is high only on bit slots that consume a sequence bit.
module lpg_qrs
    import lpg_pkg::*;
#(
    parameter int               ZERO_RUN = 14,
    parameter logic [QRS_W-1:0] SEED     = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic seq_bit
);
    localparam int ZC_W = $clog2(ZERO_RUN + 1);

    logic [QRS_W-1:0] shreg;
    logic [ZC_W-1:0]  zrun;
    logic             fb;
    logic             forced;

    // Raw feedback and the zero-run substitution for the current slot.
    always_comb begin
        fb      = shreg[QRS_TAP_HI] ^ shreg[QRS_TAP_LO];
        forced  = (zrun >= ZC_W'(ZERO_RUN));
        seq_bit = fb | forced;
    end

    // Shift the register and track the run of zeros on each consumed slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= SEED;
            zrun  <= '0;
        end else if (advance) begin
            shreg <= {shreg[QRS_W-2:0], fb};
            zrun  <= seq_bit ? '0 : zrun + ZC_W'(1);
        end
    end
endmodule

// File: rtl/lpg_loopcode.sv
// Repeating loop-code source. Two words, sent MSB first, sit right-aligned in
// MAX_LEN-bit parameters. Assumes restart is raised whenever the selected word
// changes, so the phase never exceeds the active word length.
module lpg_loopcode #(
    parameter int                 MAX_LEN = 5,
    parameter int                 UP_LEN  = 5,
    parameter logic [MAX_LEN-1:0] UP_CODE = 5'b00001,
    parameter int                 DN_LEN  = 3,
    parameter logic [MAX_LEN-1:0] DN_CODE = 5'b00001
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic restart,
    input  logic sel_down,
    output logic code_bit
);
    localparam int              PH_W    = $clog2(MAX_LEN);
    localparam logic [PH_W-1:0] UP_LAST = PH_W'(UP_LEN - 1);
    localparam logic [PH_W-1:0] DN_LAST = PH_W'(DN_LEN - 1);

    logic [PH_W-1:0]    phase;
    logic [PH_W-1:0]    ph_eff;
    logic [PH_W-1:0]    last;
    logic [MAX_LEN-1:0] word;
    logic [MAX_LEN-1:0] shifted;

    // Pick the active word and the bit at the effective phase.
    always_comb begin
        ph_eff   = restart ? '0 : phase;
        last     = sel_down ? DN_LAST : UP_LAST;
        word     = sel_down ? DN_CODE : UP_CODE;
        shifted  = word >> (last - ph_eff);
        code_bit = shifted[0];
    end

    // Step the phase, wrapping at the end of the active word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (advance) begin
            phase <= (ph_eff == last) ? '0 : ph_eff + PH_W'(1);
        end
    end
endmodule

// File: rtl/lpg_errinj.sv
// Error request capture: synchronises an asynchronous strobe, finds rising
// edges and holds one pending request until a bit slot consumes it.
// Assumes arm is low whenever error insertion is not selected.
module lpg_errinj #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic arm,
    input  logic consume,
    output logic pending
);
    logic [SYNC_STAGES:0] sync_q;
    logic                 rise;

    // Synchroniser chain plus one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], strobe};
    end

    // A rising edge appears as new-high, old-low at the end of the chain.
    always_comb rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

    // Hold one request; drop it when disarmed, clear it once consumed.
    always_ff @(posedge clk) begin
        if (!rst_n)    pending <= 1'b0;
        else if (!arm) pending <= 1'b0;
        else           pending <= rise | (pending & ~consume);
    end
endmodule

// File: rtl/line_pattern_gen.sv
// Transmit test pattern selector for one line channel. On each enabled slot
// it registers user data, ones, a loop code or the quasi-random stream, with
// optional inversion and error insertion. A loss-of-signal override forces
// ones and freezes all generator state. Assumes bit_en is in the clk domain.
module line_pattern_gen
    import lpg_pkg::*;
#(
    parameter int               ZERO_RUN    = 14,
    parameter logic [QRS_W-1:0] QRS_SEED    = '1,
    parameter int               SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       user_bit,
    input  logic [2:0] test_sel,
    input  logic       auto_ones_en,
    input  logic       rx_los,
    input  logic       err_strobe,
    output logic       tx_bit,
    output logic       tx_valid
);
    logic       override;
    logic       gen_adv;
    logic [2:0] sel_q;
    logic       restart;
    logic       is_loop;
    logic       is_qrs;
    logic       err_mode;
    logic       qrs_bit;
    logic       code_bit;
    logic       err_pending;
    logic       err_take;
    logic       next_bit;

    // Mode decode and slot qualification.
    always_comb begin
        override = auto_ones_en & rx_los;
        gen_adv  = bit_en & ~override;
        restart  = (test_sel != sel_q);
        is_loop  = (test_sel == SEL_LUP) || (test_sel == SEL_LDN);
        is_qrs   = test_sel[2];
        err_mode = test_sel[2] & test_sel[1];
        err_take = gen_adv & err_mode & err_pending;
    end

    // Remember the selector of the last generator slot for restart detection.
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= SEL_DATA;
        else if (gen_adv) sel_q <= test_sel;
    end

    lpg_qrs #(
        .ZERO_RUN (ZERO_RUN),
        .SEED     (QRS_SEED)
    ) qrs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (gen_adv & is_qrs),
        .seq_bit (qrs_bit)
    );

    lpg_loopcode loop_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (gen_adv & is_loop),
        .restart  (restart),
        .sel_down (test_sel[0]),
        .code_bit (code_bit)
    );

    lpg_errinj #(
        .SYNC_STAGES (SYNC_STAGES)
    ) err_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (err_strobe),
        .arm     (err_mode),
        .consume (err_take),
        .pending (err_pending)
    );

    // Select the bit for this slot.
    always_comb begin
        if (override) begin
            next_bit = 1'b1;
        end else if (is_qrs) begin
            next_bit = qrs_bit ^ test_sel[0] ^ err_take;
        end else begin
            case (test_sel)
                SEL_DATA: next_bit = user_bit;
                SEL_ONES: next_bit = 1'b1;
                default:  next_bit = code_bit;
            endcase
        end
    end

    // Output register, loaded only on enabled slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bit   <= 1'b0;
            tx_valid <= 1'b0;
        end else begin
            tx_valid <= bit_en;
            if (bit_en) tx_bit <= next_bit;
        end
    end
endmodule

// File: rtl/lpg_chk.sv
// Property checker for line_pattern_gen, attached through bind.
module lpg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       user_bit,
    input logic [2:0] test_sel,
    input logic       auto_ones_en,
    input logic       rx_los,
    input logic       tx_bit,
    input logic       tx_valid
);
    // R2
    valid_follows_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> tx_valid);
    // R2
    valid_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> !tx_valid);
    // R2
    bit_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));
    // R3
    data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && test_sel == 3'b000 && !(auto_ones_en && rx_los))
            |=> (tx_bit == $past(user_bit)));
    // R4
    all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && test_sel == 3'b001) |=> tx_bit);
    // R12
    los_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && auto_ones_en && rx_los) |=> tx_bit);
endmodule

bind line_pattern_gen lpg_chk chk_i (.*);

// File: tb/line_pattern_gen_tb.sv
// Self-checking bench: arithmetic reference model, sweeps over all modes.
module line_pattern_gen_tb_top;
    localparam int ZR = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       user_bit = 1'b0;
    logic [2:0] test_sel = 3'b000;
    logic       auto_ones_en = 1'b0;
    logic       rx_los = 1'b0;
    logic       err_strobe = 1'b0;
    logic       tx_bit;
    logic       tx_valid;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic [19:0] m_s;
    int          m_z;
    int          m_ph;
    logic [2:0]  m_sel;
    bit          m_pend;
    int          m_forced;
    int          m_flips;

    always #10 clk = ~clk;

    line_pattern_gen #(.ZERO_RUN(ZR)) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .user_bit(user_bit),
        .test_sel(test_sel), .auto_ones_en(auto_ones_en), .rx_los(rx_los),
        .err_strobe(err_strobe), .tx_bit(tx_bit), .tx_valid(tx_valid));

    task automatic check(input logic got, input logic exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // Reference for one enabled slot under the current inputs.
    function automatic logic model_bit(input logic [2:0] sel, input logic u,
                                       input logic ao, input logic los);
        logic b;
        logic fb;
        bit   rs;
        int   ph;
        if (ao && los) return 1'b1;
        rs = (sel != m_sel);
        m_sel = sel;
        case (sel)
            3'b000: b = u;
            3'b001: b = 1'b1;
            3'b010, 3'b011: begin
                ph = rs ? 0 : m_ph;
                if (sel == 3'b010) begin
                    b = (ph == 4);
                    m_ph = (ph == 4) ? 0 : ph + 1;
                end else begin
                    b = (ph == 2);
                    m_ph = (ph == 2) ? 0 : ph + 1;
                end
            end
            default: begin
                fb = m_s[19] ^ m_s[16];
                m_s = {m_s[18:0], fb};
                b = (m_z >= ZR) ? 1'b1 : fb;
                if (m_z >= ZR) m_forced++;
                m_z = b ? 0 : m_z + 1;
                if (sel[0]) b = ~b;
                if (sel[1] && m_pend) begin
                    b = ~b;
                    m_pend = 0;
                    m_flips++;
                end
            end
        endcase
        return b;
    endfunction

    task automatic send(input logic u, input string tag);
        logic e;
        bit_en = 1'b1;
        user_bit = u;
        e = model_bit(test_sel, u, auto_ones_en, rx_los);
        @(negedge clk);
        check(tx_valid, 1'b1, "R2");
        check(tx_bit, e, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            logic prev;
            bit_en = 1'b0;
            user_bit = ~user_bit;
            prev = tx_bit;
            @(negedge clk);
            check(tx_valid, 1'b0, "R2");
            check(tx_bit, prev, "R2");
        end
    endtask

    task automatic strobe();
        err_strobe = 1'b1;
        idle(5);
        err_strobe = 1'b0;
        idle(5);
        if (test_sel[2:1] == 2'b11) m_pend = 1;
    endtask

    function automatic string tag_of(input logic [2:0] s);
        case (s)
            3'b000: return "R3";
            3'b001: return "R4";
            3'b010: return "R5";
            3'b011: return "R6";
            3'b100: return "R8";
            3'b101: return "R10";
            default: return "R11";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tx_valid, 1'b0, "R1");
        check(tx_bit, 1'b0, "R1");
        rst_n = 1'b1;
        m_s = 20'hFFFFF; m_z = 0; m_ph = 0; m_sel = 3'b000; m_pend = 0;
        m_forced = 0; m_flips = 0;

        // sweep every mode, gaps and strobes inside
        for (int pass = 0; pass < 2; pass++) begin
            for (int s = 0; s < 8; s++) begin
                test_sel = 3'(s);
                for (int i = 0; i < 600; i++) begin
                    send(1'($urandom), tag_of(test_sel));
                    if (i % 97 == 13) idle(2);
                    if (i % 150 == 40) strobe();
                end
            end
        end

        // R7: switch loop codes mid-word
        for (int k = 0; k < 40; k++) begin
            test_sel = (k % 2 == 0) ? 3'b010 : 3'b011;
            for (int i = 0; i < (k % 4) + 1; i++) send(1'b0, "R7");
        end

        // R12: override in several modes; generators must hold
        for (int s = 0; s < 8; s++) begin
            test_sel = 3'(s);
            for (int i = 0; i < 20; i++) send(1'($urandom), tag_of(test_sel));
            auto_ones_en = 1'b1; rx_los = 1'b1;
            for (int i = 0; i < 7; i++) send(1'b0, "R12");
            rx_los = 1'b0;
            for (int i = 0; i < 9; i++) send(1'($urandom), "R12");
            auto_ones_en = 1'b0; rx_los = 1'b1;
            for (int i = 0; i < 9; i++) send(1'($urandom), "R12");
            rx_los = 1'b0;
        end

        // R9 and R11: model must have seen both events
        n_checks++;
        if (m_forced == 0) begin
            n_fail++;
            $display("FAIL R9: forced ones got %0d expected >0", m_forced);
        end
        n_checks++;
        if (m_flips == 0) begin
            n_fail++;
            $display("FAIL R11: inserted errors got %0d expected >0", m_flips);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule